// File: doc/BRIEF.md
# Parallel NOR Flash Command Controller

This block is a clocked behavioural model of the command logic inside a parallel NOR flash device. A host drives chip-enable, write-enable and output-enable strobes with an address and a data byte. Bus writes are decoded into multi-cycle unlock command sequences that program a byte, erase one sector, erase the whole chip, enter or leave a fast two-write program mode, or pause and continue an erase. A small byte array stands in for the flash cells. It is split into boot-style sectors, and each sector has a hardware lock input.

While a program or erase runs, the `ready` output is low. A read returns a status byte in place of array data. Program and erase times are fixed cycle counts set by parameters. A low level on `rst_n` stops any running operation and returns the controller to array read. Array contents survive reset, and at power-up every byte is erased to FF.

Every clock cycle with `ce_n`=0, `we_n`=0 and `oe_n`=1 counts as one bus write. Every clock cycle with `ce_n`=0, `oe_n`=0 and `we_n`=1 counts as one bus read. Command addresses are compared on `addr[10:0]`. Array bytes are selected by the low address bits.

Top module: `flash_cmd_ctl`

## Requirements
- R1: A program takes four bus writes: AA at address 555, then 55 at address 2AA, then A0 at address 555, then the target address with the data byte. The address and data are latched on the fourth write.
- R2: Programming can only clear bits. The stored byte becomes the old value AND the written value.
- R3: `ready` goes low in the cycle after the write that starts an operation. It stays low for exactly P_CYC cycles for a program and E_CYC cycles for an erase, then returns high with the controller back in array read.
- R4: A read while `ready` is low returns a status byte on `dout` one cycle later:
  - bit 7 is the complement of bit 7 of the data being programmed, and 0 during an erase;
  - bit 6 starts at 0 after reset and inverts on every such read;
  - bits 5:0 are 0.
- R5: In array read mode, `dout` shows the byte at the read address one cycle after the read. `dout` holds its value when no read takes place. After reset, `dout` is 00 and `ready` is 1.
- R6: A sector erase is AA@555, 55@2AA, 80@555, AA@555, 55@2AA, then 30 at any address inside the sector. At its start the sector is preprogrammed to 00. On completion every byte of that sector is FF, and bytes outside it are unchanged.
- R7: A chip erase is the same sequence ending with 10 at address 555. It erases every sector whose lock bit is 0.
- R8: With `lock[s]`=1, a program or sector erase aimed at sector s does not start (`ready` stays 1) and leaves its data unchanged. A chip erase skips that sector.
- R9: AA@555, 55@2AA, 20@555 enters bypass mode. There a program is two writes: A0 at any address, then address and data. The two writes 90 then 00 leave bypass mode, after which a two-write program has no effect.
- R10: A write of B0 during an erase suspends it:
  - `ready` is high in the next cycle;
  - array reads work;
  - programs to sectors outside the erase run normally;
  - a program to a sector being erased is rejected.
  A write of 30 while suspended resumes the erase, which then completes.
- R11: A wrong address or data value inside an unlock sequence, or a write of F0, returns the controller to array read without changing memory. Writes that follow are treated as new commands.
- R12: Asserting `rst_n` low aborts a running operation and returns `ready` high, with the controller in array read. Bytes already preprogrammed by an aborted erase stay 00, and the status toggle bit restarts at 0.
- R13: The sector map is measured in units of SU bytes.
  - With TOP_BOOT=0, from address 0 the sectors are 2, 1, 1 and 4 units long, followed by NMAIN sectors of 8 units each.
  - With TOP_BOOT=1, the NMAIN 8-unit sectors come first, followed by sectors of 4, 1, 1 and 2 units.
  - Sector indices count up from address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; aborts operations |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Byte address; low 11 bits used for command decode |
| din | input | 8 | Write data / command byte |
| lock | input | NMAIN+4 | Per-sector protection, 1 = locked |
| dout | output | 8 | Read data or status byte |
| ready | output | 1 | High when no program or erase is running |

## Verification
A read's result appears on `dout` one cycle after the read strobe. The monitor therefore samples 2 ns after the edge that captured the read, and pops the expected byte that the read task pushed. `ready` falls in the cycle after the final command write. The bench counts the negative edges at which `ready` is low, starting right after that write, and compares the count against P_CYC or E_CYC. Rejected commands, suspends and resets are judged by `ready` at the negative edge just after the write or reset edge. Their effect on memory is then read back through later array reads.

// File: rtl/flash_cmd_ctl.sv
module flash_cmd_ctl #(
  parameter int SU = 2,
  parameter int NMAIN = 31,
  parameter int TOP_BOOT = 0,
  parameter int P_CYC = 8,
  parameter int E_CYC = 40,
  parameter int AW = 11,
  localparam int NS = NMAIN + 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  input  logic [NS-1:0] lock,
  output logic [7:0]    dout,
  output logic          ready
);
  localparam int MSZ = SU * (8 + 8 * NMAIN);
  localparam int MAW = $clog2(MSZ);
  localparam int SW  = $clog2(NS);
  localparam int CMX = (E_CYC > P_CYC) ? E_CYC : P_CYC;
  localparam int CW  = $clog2(CMX + 1);

  typedef enum logic [3:0] {S_RD, S_U1, S_U2, S_E1, S_E2, S_E3, S_PG, S_BX, S_PB, S_EB} st_t;

  function automatic logic [SW-1:0] sec_of(input int a);
    int u;
    u = a / SU;
    if (TOP_BOOT == 0) begin
      if (u < 2) return SW'(0);
      if (u < 3) return SW'(1);
      if (u < 4) return SW'(2);
      if (u < 8) return SW'(3);
      return SW'(4 + (u - 8) / 8);
    end
    if (u < 8 * NMAIN) return SW'(u / 8);
    u = u - 8 * NMAIN;
    if (u < 4) return SW'(NMAIN);
    if (u < 5) return SW'(NMAIN + 1);
    if (u < 6) return SW'(NMAIN + 2);
    return SW'(NMAIN + 3);
  endfunction

  st_t st;
  logic byp, susp, tgl;
  logic [NS-1:0] emask;
  logic [CW-1:0] pcnt, ecnt;
  logic [MAW-1:0] pa;
  logic [7:0] pd;
  logic [7:0] mem [MSZ];

  wire wr   = !ce_n && !we_n && oe_n;
  wire rd   = !ce_n && !oe_n && we_n;
  wire a555 = addr[10:0] == 11'h555;
  wire a2aa = addr[10:0] == 11'h2AA;
  wire [MAW-1:0] ma = addr[MAW-1:0];
  wire [SW-1:0] sec = sec_of(int'(ma));
  wire busy = (st == S_PB) || (st == S_EB);
  assign ready = !busy;

  wire chip_go = wr && din == 8'h10 && a555 && (|(~lock));
  wire sect_go = wr && din == 8'h30 && !lock[sec];
  wire e_go    = (st == S_E3) && (chip_go || sect_go);
  wire [NS-1:0] nmask = chip_go ? ~lock : (NS'(1) << sec);
  wire s_req   = (st == S_EB) && wr && din == 8'hB0;
  wire e_done  = (st == S_EB) && !s_req && ecnt == '0;
  wire p_done  = (st == S_PB) && pcnt == '0;
  wire p_ok    = !lock[sec] && !(susp && emask[sec]);

  initial for (int i = 0; i < MSZ; i++) mem[i] = 8'hFF;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_RD; byp <= 1'b0; susp <= 1'b0; emask <= '0;
      pcnt <= '0; ecnt <= '0; pa <= '0; pd <= '0;
    end else begin
      case (st)
        S_RD: if (wr) begin
          if (byp) begin
            if (din == 8'hA0) st <= S_PG;
            else if (din == 8'h90) st <= S_BX;
          end else if (din == 8'hAA && a555) st <= S_U1;
          else if (din == 8'h30 && susp) begin
            susp <= 1'b0;
            st <= S_EB;
          end
        end
        S_U1: if (wr) st <= (din == 8'h55 && a2aa) ? S_U2 : S_RD;
        S_U2: if (wr) begin
          st <= S_RD;
          if (a555) begin
            if (din == 8'hA0) st <= S_PG;
            else if (din == 8'h80 && !susp) st <= S_E1;
            else if (din == 8'h20 && !susp) byp <= 1'b1;
          end
        end
        S_E1: if (wr) st <= (din == 8'hAA && a555) ? S_E2 : S_RD;
        S_E2: if (wr) st <= (din == 8'h55 && a2aa) ? S_E3 : S_RD;
        S_E3: if (wr) begin
          st <= S_RD;
          if (e_go) begin
            emask <= nmask;
            ecnt <= CW'(E_CYC - 1);
            st <= S_EB;
          end
        end
        S_PG: if (wr) begin
          st <= S_RD;
          if (p_ok) begin
            pa <= ma; pd <= din;
            pcnt <= CW'(P_CYC - 1);
            st <= S_PB;
          end
        end
        S_BX: if (wr) begin
          st <= S_RD;
          if (din == 8'h00) byp <= 1'b0;
        end
        S_PB: if (p_done) st <= S_RD; else pcnt <= pcnt - 1'b1;
        S_EB: if (s_req) begin
          susp <= 1'b1;
          st <= S_RD;
        end else if (e_done) begin
          emask <= '0;
          st <= S_RD;
        end else ecnt <= ecnt - 1'b1;
        default: st <= S_RD;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (p_done) mem[pa] <= mem[pa] & pd;
    for (int i = 0; i < MSZ; i++) begin
      if (e_go && nmask[sec_of(i)]) mem[i] <= 8'h00;
      if (e_done && emask[sec_of(i)]) mem[i] <= 8'hFF;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= 8'h00;
      tgl <= 1'b0;
    end else if (rd) begin
      if (busy) begin
        dout <= {(st == S_PB) ? ~pd[7] : 1'b0, tgl, 6'b0};
        tgl <= ~tgl;
      end else dout <= mem[ma];
    end
  end
endmodule

module flash_cmd_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ce_n,
  input logic       we_n,
  input logic       oe_n,
  input logic [7:0] dout,
  input logic       ready
);
  wire wr = !ce_n && !we_n && oe_n;
  wire rd = !ce_n && !oe_n && we_n;

  AST_BUSY_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n) $fell(ready) |-> $past(wr)); // R3
  AST_BUSY_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n) $fell(ready) |=> !ready); // R3
  AST_STATUS_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (rd && !ready) |=> dout[5:0] == 6'h00); // R4
  AST_STATUS_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n) (rd && !ready) ##1 (rd && !ready) |=> dout[6] != $past(dout[6])); // R4
  AST_DOUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !rd |=> $stable(dout)); // R5
endmodule

bind flash_cmd_ctl flash_cmd_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .dout(dout), .ready(ready)
);

// File: tb/tb_flash_cmd_ctl.sv
module tb_flash_cmd_ctl;
  localparam int NS = 35;
  localparam int PC = 8;
  localparam int EC = 40;

  logic clk = 1'b0;
  logic rst_n, ce_n, we_n, oe_n;
  logic [10:0] addr;
  logic [7:0] din;
  logic [NS-1:0] lock;
  logic [7:0] dout;
  logic ready;

  int nchk = 0, nerr = 0;
  bit tg = 1'b0;
  bit fin = 1'b0;

  typedef struct { logic [7:0] e; string tag; } item_t;
  item_t q[$];

  always #4 clk = ~clk;

  flash_cmd_ctl #(.P_CYC(PC), .E_CYC(EC)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .lock(lock), .dout(dout), .ready(ready)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!fin) begin
      fin = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  task automatic wr(input logic [10:0] a, input logic [7:0] d);
    addr = a; din = d; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic rd(input logic [10:0] a, input logic [7:0] e, input string tag);
    item_t it;
    it.e = e; it.tag = tag;
    q.push_back(it);
    addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic rd_stat(input bit b7, input string tag);
    rd(11'h0, {b7, tg, 6'b0}, tag);
    tg = ~tg;
  endtask

  task automatic unlock();
    wr(11'h555, 8'hAA);
    wr(11'h2AA, 8'h55);
  endtask

  task automatic prog(input logic [10:0] a, input logic [7:0] d);
    unlock(); wr(11'h555, 8'hA0); wr(a, d);
  endtask

  task automatic erase_pre();
    unlock(); wr(11'h555, 8'h80); unlock();
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!ready && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      if (!ce_n && !oe_n && we_n) begin
        #2;
        if (q.size() == 0) check(1'b0, "monitor: read with no expected item", 0, 1);
        else begin
          item_t it;
          it = q.pop_front();
          check(dout == it.e, it.tag, dout, it.e);
        end
      end
    end
  end

  initial begin : watchdog
    #(8 * 150000);
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin : stim
    int n;
    rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    addr = '0; din = '0; lock = '0;
    repeat (3) @(negedge clk);
    check(ready == 1'b1, "R5 reset ready", ready, 1);
    check(dout == 8'h00, "R5 reset dout", dout, 0);
    rst_n = 1'b1;
    @(negedge clk);

    rd(11'h100, 8'hFF, "R5 erased byte read");

    prog(11'h100, 8'h3C);
    wait_ready(n);
    check(n == PC, "R3 program busy length", n, PC);
    rd(11'h100, 8'h3C, "R1 four-write program");

    prog(11'h100, 8'hF0);
    wait_ready(n);
    rd(11'h100, 8'h30, "R2 bits only clear");

    prog(11'h101, 8'h5A);
    rd_stat(1'b1, "R4 program status first");
    rd_stat(1'b1, "R4 program status second");
    wait_ready(n);
    rd(11'h101, 8'h5A, "R4 data after status");

    prog(11'h003, 8'h00); wait_ready(n);
    prog(11'h004, 8'h00); wait_ready(n);
    prog(11'h005, 8'h00); wait_ready(n);
    prog(11'h006, 8'h00); wait_ready(n);
    erase_pre(); wr(11'h005, 8'h30);
    wait_ready(n);
    check(n == EC, "R3 erase busy length", n, EC);
    rd(11'h003, 8'h00, "R6 byte below sector kept");
    rd(11'h004, 8'hFF, "R6 sector first byte erased");
    rd(11'h005, 8'hFF, "R6 sector last byte erased");
    rd(11'h006, 8'h00, "R13 next sector kept");

    prog(11'h00F, 8'h00); wait_ready(n);
    prog(11'h010, 8'h00); wait_ready(n);
    erase_pre(); wr(11'h008, 8'h30);
    rd_stat(1'b0, "R4 erase status");
    wait_ready(n);
    rd(11'h00F, 8'hFF, "R13 sector3 end erased");
    rd(11'h010, 8'h00, "R13 sector4 start kept");

    prog(11'h028, 8'h12); wait_ready(n);
    lock[5] = 1'b1;
    prog(11'h028, 8'h00);
    check(ready == 1'b1, "R8 locked program not started", ready, 1);
    erase_pre(); wr(11'h021, 8'h30);
    check(ready == 1'b1, "R8 locked erase not started", ready, 1);
    rd(11'h028, 8'h12, "R8 locked data unchanged");

    wr(11'h555, 8'hAA); wr(11'h2AB, 8'h55); wr(11'h555, 8'hA0); wr(11'h100, 8'h00);
    check(ready == 1'b1, "R11 bad address no busy", ready, 1);
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'hF0); wr(11'h2AA, 8'h55); wr(11'h555, 8'hA0); wr(11'h100, 8'h00);
    check(ready == 1'b1, "R11 F0 abort no busy", ready, 1);
    rd(11'h100, 8'h30, "R11 memory unchanged");

    unlock(); wr(11'h555, 8'h20);
    wr(11'h000, 8'hA0); wr(11'h102, 8'h11);
    wait_ready(n);
    check(n == PC, "R9 bypass program busy", n, PC);
    wr(11'h000, 8'hA0); wr(11'h103, 8'h22); wait_ready(n);
    wr(11'h000, 8'h90); wr(11'h000, 8'h00);
    wr(11'h000, 8'hA0); wr(11'h104, 8'h00);
    check(ready == 1'b1, "R9 program ignored after exit", ready, 1);
    rd(11'h102, 8'h11, "R9 bypass byte 1");
    rd(11'h103, 8'h22, "R9 bypass byte 2");
    rd(11'h104, 8'hFF, "R9 after exit unchanged");

    prog(11'h1A0, 8'h00); wait_ready(n);
    erase_pre(); wr(11'h1A0, 8'h30);
    repeat (3) @(negedge clk);
    wr(11'h000, 8'hB0);
    check(ready == 1'b1, "R10 suspend ready high", ready, 1);
    rd(11'h100, 8'h30, "R10 read during suspend");
    prog(11'h105, 8'h0F);
    wait_ready(n);
    check(n == PC, "R10 program during suspend", n, PC);
    rd(11'h105, 8'h0F, "R10 programmed during suspend");
    prog(11'h1A1, 8'h00);
    check(ready == 1'b1, "R10 program to erasing sector rejected", ready, 1);
    wr(11'h000, 8'h30);
    check(ready == 1'b0, "R10 resume busy", ready, 0);
    wait_ready(n);
    rd(11'h1A0, 8'hFF, "R10 erase finished 1A0");
    rd(11'h1A1, 8'hFF, "R10 erase finished 1A1");

    erase_pre(); wr(11'h555, 8'h10);
    wait_ready(n);
    check(n == EC, "R7 chip erase busy", n, EC);
    rd(11'h100, 8'hFF, "R7 chip erased 100");
    rd(11'h105, 8'hFF, "R7 chip erased 105");
    rd(11'h028, 8'h12, "R8 chip erase skips locked");

    prog(11'h1B0, 8'h55); wait_ready(n);
    erase_pre(); wr(11'h1B0, 8'h30);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(ready == 1'b1, "R12 reset aborts", ready, 1);
    @(negedge clk);
    rst_n = 1'b1;
    tg = 1'b0;
    @(negedge clk);
    rd(11'h1B0, 8'h00, "R12 preprogram kept 1B0");
    rd(11'h1BF, 8'h00, "R12 preprogram kept 1BF");
    rd(11'h1C0, 8'hFF, "R12 next sector kept");
    prog(11'h1C0, 8'h80);
    rd_stat(1'b0, "R12 toggle restarts");
    rd_stat(1'b0, "R12 toggle second");
    wait_ready(n);
    rd(11'h1C0, 8'h80, "R1 program after reset");

    repeat (4) @(negedge clk);
    check(q.size() == 0, "monitor queue drained", q.size(), 0);
    finish_run();
  end
endmodule